// File: doc/BRIEF.md
# Serial Flash Deep Power-Down Release Responder

This block is the slave-side command logic that takes a serial flash device out of its deep power-down state. It watches the serial clock, chip-select and data-input pins in SPI mode 0, oversampled by the system clock through synchronisers. It counts rising serial clock edges while chip-select is low and decodes the first byte as an opcode. It tracks whether the device is in standby or in deep power-down. It also accepts the one command that enters deep power-down.

The release command has two forms. In the short form, chip-select rises straight after the opcode byte. In the long form, three dummy bytes follow the opcode, and the device then shifts out a one-byte identification value on its data output for as long as chip-select stays low. Each form starts its own wake-up delay, counted in system clocks and set by a parameter. A busy flag is held for the length of the delay, and standby follows when it ends.

Top module: `pd_release_resp`

## Requirements
- R1: After reset the device is in standby: dpd_o = 0, busy_o = 0, miso_oe_o = 0.
- R2: In standby, opcode 0xB9 (sampled MSB first on rising sck_i) followed by csn_i high after exactly 8 bits sets dpd_o to 1. Any other bit count leaves the device in standby.
- R3: In deep power-down, opcode 0xAB with csn_i high after exactly 8 bits sets busy_o for exactly T_RES1 clocks. dpd_o then falls in the same cycle as busy_o.
- R4: In deep power-down, opcode 0xAB followed by at least 32 bits before csn_i rises sets busy_o for exactly T_RES2 clocks, and standby follows.
- R5: After opcode 0xAB and three dummy bytes, each falling sck_i edge from the one after the 32nd rising edge onward drives the next bit of SIG_VALUE (0x13), MSB first, with miso_oe_o = 1. The byte repeats while csn_i stays low. This works in both standby and deep power-down.
- R6: miso_oe_o stays 0 during the opcode and dummy bits, and for any opcode other than 0xAB. Whenever miso_oe_o is 0, miso_o is 0.
- R7: In deep power-down, any opcode other than 0xAB is ignored. Opcode 0xAB with 9 to 31 bits before csn_i rises is also ignored, and the device stays in deep power-down.
- R8: A frame that starts while busy_o is high is ignored. In particular, 0xB9 sent during the wake-up delay does not re-enter deep power-down.
- R9: In standby, the short form of 0xAB has no effect: busy_o stays 0 and dpd_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock, mode 0 |
| csn_i | input | 1 | Chip select, active low |
| mosi_i | input | 1 | Serial data into the device |
| miso_o | output | 1 | Serial data out of the device |
| miso_oe_o | output | 1 | Output enable for miso_o (0 = high impedance) |
| dpd_o | output | 1 | Device is in deep power-down or still waking |
| busy_o | output | 1 | Wake-up delay running |

## Verification
The hardest situation to reach from the ports is a frame that arrives while a wake-up delay is running. The bench starts a short release, waits until busy_o is seen high, and then at once sends an enter-power-down frame inside the delay window. Random frames mix the two opcodes, foreign opcodes and bit counts around 8 and 32. They run against a bench model of the power state, so that the long form is also exercised from standby and signature repeats beyond one byte are checked.

// File: rtl/flash_pd_pkg.sv
package flash_pd_pkg;
  localparam logic [7:0] OP_RELEASE = 8'hAB;
  localparam logic [7:0] OP_ENTER   = 8'hB9;
  localparam logic [7:0] SIG_DEFAULT = 8'h13;

  typedef enum logic [1:0] {
    PWR_STBY = 2'd0,
    PWR_DEEP = 2'd1,
    PWR_WAKE = 2'd2
  } pwr_state_e;
endpackage

// File: rtl/pd_spi_sync.sv
module pd_spi_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic csn_i,
  input  logic mosi_i,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic cs_fall_o,
  output logic cs_rise_o,
  output logic mosi_o
);
  // pin order inside a stage: {sck, csn, mosi}
  logic [SYNC_STAGES-1:0][2:0] stg_q;
  logic [1:0] prev_q;
  logic sck_s, csn_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SYNC_STAGES; s++) stg_q[s] <= 3'b010;
    end else begin
      stg_q[0] <= {sck_i, csn_i, mosi_i};
      for (int s = 1; s < SYNC_STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign sck_s  = stg_q[SYNC_STAGES-1][2];
  assign csn_s  = stg_q[SYNC_STAGES-1][1];
  assign mosi_o = stg_q[SYNC_STAGES-1][0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 2'b01;
    else         prev_q <= {sck_s, csn_s};
  end

  assign sck_rise_o = sck_s & ~prev_q[1];
  assign sck_fall_o = ~sck_s & prev_q[1];
  assign cs_fall_o  = ~csn_s & prev_q[0];
  assign cs_rise_o  = csn_s & ~prev_q[0];
endmodule

// File: rtl/pd_cmd_rx.sv
module pd_cmd_rx #(
  parameter int DUMMY_BYTES = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       sck_rise_i,
  input  logic       cs_fall_i,
  input  logic       cs_rise_i,
  input  logic       mosi_i,
  output logic [7:0] opcode_o,
  output logic       frame_end_o,
  output logic       len8_o,
  output logic       long_o,
  output logic       out_phase_o
);
  localparam int SIG_START = 8 * (1 + DUMMY_BYTES);
  localparam int CNT_W     = $clog2(SIG_START + 1);

  logic             act_q;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       sh_q, op_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
      sh_q  <= '0;
      op_q  <= '0;
    end else if (cs_fall_i) begin
      // a frame is only accepted if it starts while decoding is enabled
      act_q <= en_i;
      cnt_q <= '0;
      op_q  <= '0;
    end else if (cs_rise_i || !en_i) begin
      act_q <= 1'b0;
    end else if (act_q && sck_rise_i) begin
      sh_q <= {sh_q[6:0], mosi_i};
      if (cnt_q != CNT_W'(SIG_START)) cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_W'(7)) op_q <= {sh_q[6:0], mosi_i};
    end
  end

  assign opcode_o    = op_q;
  assign frame_end_o = cs_rise_i & act_q;
  assign len8_o      = (cnt_q == CNT_W'(8));
  assign long_o      = (cnt_q == CNT_W'(SIG_START));
  assign out_phase_o = act_q & long_o;
endmodule

// File: rtl/pd_sig_tx.sv
module pd_sig_tx #(
  parameter int         SIG_W     = 8,
  parameter logic [SIG_W-1:0] SIG_VALUE = 8'h13
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic armed_i,
  input  logic sck_fall_i,
  input  logic cs_fall_i,
  input  logic cs_rise_i,
  output logic miso_o,
  output logic miso_oe_o
);
  localparam int IDX_W = $clog2(SIG_W);

  logic [IDX_W-1:0] idx_q;
  logic             bit_q, oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      bit_q <= 1'b0;
      oe_q  <= 1'b0;
    end else if (cs_fall_i || cs_rise_i || !armed_i) begin
      idx_q <= '0;
      bit_q <= 1'b0;
      oe_q  <= 1'b0;
    end else if (sck_fall_i) begin
      bit_q <= SIG_VALUE[IDX_W'(SIG_W-1) - idx_q];
      idx_q <= (idx_q == IDX_W'(SIG_W-1)) ? '0 : idx_q + 1'b1;
      oe_q  <= 1'b1;
    end
  end

  assign miso_o    = bit_q & oe_q;
  assign miso_oe_o = oe_q;
endmodule

// File: rtl/pd_pwr_fsm.sv
module pd_pwr_fsm
  import flash_pd_pkg::*;
#(
  parameter int T_RES1 = 300,
  parameter int T_RES2 = 1800
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       frame_end_i,
  input  logic       len8_i,
  input  logic       long_i,
  input  logic [7:0] opcode_i,
  output logic       dec_en_o,
  output logic       dpd_o,
  output logic       busy_o
);
  localparam int TMAX = (T_RES1 > T_RES2) ? T_RES1 : T_RES2;
  localparam int TW   = $clog2(TMAX + 1);

  pwr_state_e     st_q, st_d;
  logic [TW-1:0]  cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      PWR_STBY: if (frame_end_i && len8_i && opcode_i == OP_ENTER) st_d = PWR_DEEP;
      PWR_DEEP: begin
        if (frame_end_i && opcode_i == OP_RELEASE) begin
          if (len8_i) begin
            st_d  = PWR_WAKE;
            cnt_d = TW'(T_RES1 - 1);
          end else if (long_i) begin
            st_d  = PWR_WAKE;
            cnt_d = TW'(T_RES2 - 1);
          end
        end
      end
      PWR_WAKE: begin
        if (cnt_q == '0) st_d = PWR_STBY;
        else             cnt_d = cnt_q - 1'b1;
      end
      default: st_d = PWR_STBY;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= PWR_STBY;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign dec_en_o = (st_q != PWR_WAKE);
  assign dpd_o    = (st_q != PWR_STBY);
  assign busy_o   = (st_q == PWR_WAKE);
endmodule

// File: rtl/pd_release_resp.sv
module pd_release_resp
  import flash_pd_pkg::*;
#(
  parameter int         T_RES1      = 300,
  parameter int         T_RES2      = 1800,
  parameter int         DUMMY_BYTES = 3,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] SIG_VALUE   = SIG_DEFAULT
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic csn_i,
  input  logic mosi_i,
  output logic miso_o,
  output logic miso_oe_o,
  output logic dpd_o,
  output logic busy_o
);
  logic sck_rise, sck_fall, cs_fall, cs_rise, mosi_s;
  logic [7:0] opcode;
  logic frame_end, len8, long_frm, out_phase, dec_en;

  pd_spi_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .sck_i, .csn_i, .mosi_i,
    .sck_rise_o(sck_rise), .sck_fall_o(sck_fall),
    .cs_fall_o(cs_fall), .cs_rise_o(cs_rise), .mosi_o(mosi_s)
  );

  pd_cmd_rx #(.DUMMY_BYTES(DUMMY_BYTES)) u_rx (
    .clk_i, .rst_ni, .en_i(dec_en),
    .sck_rise_i(sck_rise), .cs_fall_i(cs_fall), .cs_rise_i(cs_rise),
    .mosi_i(mosi_s), .opcode_o(opcode), .frame_end_o(frame_end),
    .len8_o(len8), .long_o(long_frm), .out_phase_o(out_phase)
  );

  pd_sig_tx #(.SIG_W(8), .SIG_VALUE(SIG_VALUE)) u_tx (
    .clk_i, .rst_ni,
    .armed_i(out_phase && opcode == OP_RELEASE),
    .sck_fall_i(sck_fall), .cs_fall_i(cs_fall), .cs_rise_i(cs_rise),
    .miso_o, .miso_oe_o
  );

  pd_pwr_fsm #(.T_RES1(T_RES1), .T_RES2(T_RES2)) u_pwr (
    .clk_i, .rst_ni, .frame_end_i(frame_end), .len8_i(len8),
    .long_i(long_frm), .opcode_i(opcode),
    .dec_en_o(dec_en), .dpd_o, .busy_o
  );
endmodule

// File: rtl/pd_release_resp_chk.sv
module pd_release_resp_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic miso_o,
  input logic miso_oe_o,
  input logic dpd_o,
  input logic busy_o
);
  a_r3_busy_within_dpd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> dpd_o);

  a_r4_wake_only_from_deep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(dpd_o));

  a_r3_standby_after_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !dpd_o);

  a_r8_no_entry_from_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dpd_o) |-> !$past(busy_o));

  a_r6_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !miso_oe_o |-> !miso_o);

  a_r5_no_drive_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miso_oe_o |-> !busy_o);
endmodule

bind pd_release_resp pd_release_resp_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .miso_o(miso_o),
  .miso_oe_o(miso_oe_o), .dpd_o(dpd_o), .busy_o(busy_o)
);

// File: tb/pd_release_resp_tb_top.sv
module pd_release_resp_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 6;
  localparam int T1         = 150;
  localparam int T2         = 220;
  localparam logic [7:0] SIG = 8'h13;
  localparam logic [7:0] REL = 8'hAB;
  localparam logic [7:0] ENT = 8'hB9;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, csn = 1'b1, mosi = 1'b0;
  logic miso, miso_oe, dpd, busy;
  int n_chk = 0, n_fail = 0;
  bit mdl_dpd = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pd_release_resp #(.T_RES1(T1), .T_RES2(T2)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .csn_i(csn), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(miso_oe), .dpd_o(dpd), .busy_o(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic sig_bit(input int i);
    return SIG[7 - ((i - 32) % 8)];
  endfunction

  // one chip-select frame; checks the output pin bit by bit
  task automatic frame(input logic [7:0] op, input int nbits, input bit sig_ok);
    int bad_d = 0, bad_q = 0;
    @(negedge clk) csn = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 8) ? op[7-i] : 1'($urandom % 2);
      repeat (HALF) @(negedge clk);
      if (sig_ok && op == REL && i >= 32) begin
        if (!miso_oe || miso != sig_bit(i)) bad_d++;
      end else if (miso_oe || miso) bad_q++;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    if (sig_ok && op == REL && nbits > 32) chk(bad_d == 0, "R5 signature bits", bad_d, 0);
    chk(bad_q == 0, "R6 output quiet", bad_q, 0);
    csn = 1'b1;
  endtask

  task automatic settle(input int t, input bit exp_dpd, input string req);
    int len = 0, wait_c = 0, seen = 0;
    if (t > 0) begin
      while (!busy && wait_c < 10) begin @(negedge clk); wait_c++; end
      while (busy && len < t + 40) begin @(negedge clk); len++; end
      chk(len == t, req, len, t);
      chk(!dpd && !busy, req, dpd, 0);
    end else begin
      for (int k = 0; k < 10; k++) begin @(negedge clk); if (busy) seen++; end
      chk(seen == 0, req, seen, 0);
      chk(dpd == exp_dpd, req, dpd, exp_dpd);
    end
  endtask

  task automatic run(input logic [7:0] op, input int nbits);
    int t = 0;
    bit nd = mdl_dpd;
    string req;
    if (!mdl_dpd) begin
      if (op == ENT && nbits == 8) nd = 1'b1;
      req = (op == REL && nbits == 8) ? "R9 standby short release" : "R2 enter decode";
    end else if (op == REL && nbits == 8) begin
      t = T1; req = "R3 short release delay";
    end else if (op == REL && nbits >= 32) begin
      t = T2; req = "R4 long release delay";
    end else begin
      req = "R7 ignored in deep";
    end
    frame(op, nbits, 1'b1);
    settle(t, nd, req);
    mdl_dpd = (t > 0) ? 1'b0 : nd;
  endtask

  initial begin
    repeat (CLK_PERIOD * 0 + 150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!dpd && !busy && !miso_oe, "R1 reset state", {dpd, busy, miso_oe}, 0);

    run(ENT, 16);            // R2 wrong length
    run(ENT, 8);             // R2 entry
    chk(dpd == 1'b1, "R2 in deep", dpd, 1);
    run(8'h03, 8);           // R7 foreign opcode
    run(REL, 20);            // R7 partial dummy bytes
    run(REL, 8);             // R3
    run(REL, 40);            // R5 from standby
    run(REL, 8);             // R9
    run(ENT, 8);
    run(REL, 56);            // R4 + R5 repeat

    // R8: enter command sent inside the wake-up window
    run(ENT, 8);
    frame(REL, 8, 1'b1);
    begin
      int w = 0;
      while (!busy && w < 10) begin @(negedge clk); w++; end
    end
    frame(ENT, 8, 1'b0);
    chk(busy == 1'b1, "R8 frame inside delay", busy, 1);
    while (busy) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(dpd == 1'b0, "R8 enter ignored while busy", dpd, 0);
    mdl_dpd = 1'b0;

    for (int n = 0; n < 50; n++) begin
      logic [7:0] op;
      int nb;
      case ($urandom % 4)
        0, 3:    op = REL;
        1:       op = ENT;
        default: op = 8'($urandom);
      endcase
      case ($urandom % 5)
        0, 3:    nb = 8;
        1:       nb = 9 + int'($urandom % 23);
        2:       nb = 32 + int'($urandom % 17);
        default: nb = 32 + 8 * int'($urandom % 3);
      endcase
      run(op, nb);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule